// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the word address that a memory-reference instruction operates on. A sequencer presents a 16-bit instruction word together with the current program counter, base register and index register, and pulses `start`. The block reads three mode bits from the instruction and sign-extends its 8-bit displacement. It then forms one of eight addresses. There are two direct single-base forms (program counter or base), an index-relative form and a base-plus-index form. There are also four indirect forms. These read a pointer word from memory and may add the index register to it afterwards.

In the indirect forms, the base register is added before the memory read and the index register is added after it. The block drives a single-outstanding read request toward memory and waits any number of cycles for the returned word. When the final address is ready, it raises `done` for one cycle with the address on `ea`. Opcode execution, register storage and translation to physical addresses are handled elsewhere.

Top module: `ea_unit`

## Requirements
- R1: Instruction fields are fixed. Bit 10 selects index-relative, bit 9 selects indirect and bit 8 selects base-relative addressing. Bits 7..0 are a two's complement displacement sign-extended to 16 bits. Bits 15..11 have no effect on the address.
- R2: Mode bits {10,9,8} = 000 give P+d and 001 give B+d. `done` is high with that `ea` in the cycle after the accepted start.
- R3: Mode 100 gives X+d, and `done` is high in the cycle after the accepted start.
- R4: Mode 101 gives B+X+d. `done` is low in the cycle after start and high in the cycle after that.
- R5: Modes 010 and 011 place P+d or B+d on `mem_addr` and raise `mem_req` in the cycle after start. Both are held unchanged until `mem_valid` is sampled high. `ea` then equals `mem_rdata`, with `done` high and `mem_req` low in the next cycle.
- R6: Modes 110 and 111 use the same pointer as 010 and 011, not offset by X. The final address is the fetched word plus the X value captured at start.
- R7: Every sum wraps modulo 2^16.
- R8: `busy` is high from the cycle after an accepted start until `done`. While `busy` is high, `start` is ignored. `pc_in`, `b_in` and `x_in` are sampled only at an accepted start.
- R9: Each accepted start yields exactly one `done` cycle. `ea` changes only in a `done` cycle, and `done` never coincides with `busy` or `mem_req`.
- R10: While reset is asserted and afterwards until the first start, `busy`, `done` and `mem_req` are low and `ea` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address formation (accepted when not busy) |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Program counter value |
| b_in | input | 16 | Base register value |
| x_in | input | 16 | Index register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, `ea` valid |
| ea | output | 16 | Effective address |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Pointer word |

## Verification
The bench builds the unit with its default parameters: 16-bit address and instruction words, an 8-bit displacement and the mode field starting at bit 8. These values bring both displacement extremes (+127 and -128) into reach, along with carries out of bit 15 in every adder stage. Memory latency is varied from zero to eight cycles. This exposes the hold of the request and the post-index path. A start pulsed during a long fetch, and register inputs scrambled after each start, exercise the input-capture rules.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INDEX = 2'd1,
    ST_FETCH = 2'd2
  } ea_state_e;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_INDEX  = 2'd1,
    SRC_FETCH  = 2'd2
  } ea_src_e;

  typedef struct packed {
    logic xrel;
    logic ind;
    logic brel;
  } ea_mode_t;

endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode
  import ea_pkg::*;
#(
  parameter int IW       = 16,
  parameter int AW       = 16,
  parameter int DISP_W   = 8,
  parameter int MODE_POS = 8
) (
  input  logic [IW-1:0] instr,
  output ea_mode_t      mode,
  output logic [AW-1:0] disp_ext
);

  localparam int EXT_W = AW - DISP_W;

  assign mode.brel = instr[MODE_POS];
  assign mode.ind  = instr[MODE_POS+1];
  assign mode.xrel = instr[MODE_POS+2];

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{instr[DISP_W-1]}}, instr[DISP_W-1:0]};
    end else begin : g_trunc
      assign disp_ext = instr[AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  ea_mode_t mode,
  input  logic     mem_valid,
  output logic     busy,
  output logic     ld_acc,
  output logic     ld_ea,
  output ea_src_e  ea_src,
  output logic     post_idx,
  output logic     mem_req,
  output logic     done
);

  ea_state_e state_q, state_d;
  logic      req_q, req_d;
  logic      post_q, post_d;
  logic      done_q, done_d;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    post_d  = post_q;
    done_d  = 1'b0;
    ld_acc  = 1'b0;
    ld_ea   = 1'b0;
    ea_src  = SRC_DIRECT;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (mode.ind) begin
            ld_acc  = 1'b1;
            post_d  = mode.xrel;
            req_d   = 1'b1;
            state_d = ST_FETCH;
          end else if (mode.xrel && mode.brel) begin
            ld_acc  = 1'b1;
            state_d = ST_INDEX;
          end else begin
            ld_ea  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      ST_INDEX: begin
        ea_src  = SRC_INDEX;
        ld_ea   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FETCH: begin
        ea_src = SRC_FETCH;
        if (mem_valid) begin
          ld_ea   = 1'b1;
          done_d  = 1'b1;
          req_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        req_d   = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      post_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      post_q  <= post_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign post_idx = post_q;
  assign mem_req  = req_q;
  assign done     = done_q;

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ea_mode_t      mode,
  input  logic [AW-1:0] disp_ext,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] b_in,
  input  logic [AW-1:0] x_in,
  input  logic          ld_acc,
  input  logic          ld_ea,
  input  ea_src_e       ea_src,
  input  logic          post_idx,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] acc,
  output logic [AW-1:0] ea
);

  logic [AW-1:0] base;
  logic [AW-1:0] first_sum;
  logic [AW-1:0] post_a, post_b, post_sum;
  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] xhold_q, xhold_d;
  logic [AW-1:0] ea_q, ea_d;

  // Stage one: base selection and displacement add (pre-indexing by B).
  always_comb begin
    if (mode.brel)                 base = b_in;
    else if (mode.xrel && !mode.ind) base = x_in;
    else                           base = pc_in;
    first_sum = base + disp_ext;
  end

  // Stage two: shared adder for B+X completion and post-indexing by X.
  always_comb begin
    post_a   = (ea_src == SRC_INDEX) ? acc_q : mem_rdata;
    post_b   = ((ea_src == SRC_INDEX) || post_idx) ? xhold_q : '0;
    post_sum = post_a + post_b;
  end

  always_comb begin
    acc_d   = ld_acc ? first_sum : acc_q;
    xhold_d = ld_acc ? x_in : xhold_q;
    ea_d    = ea_q;
    if (ld_ea) ea_d = (ea_src == SRC_DIRECT) ? first_sum : post_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      xhold_q <= '0;
      ea_q    <= '0;
    end else begin
      acc_q   <= acc_d;
      xhold_q <= xhold_d;
      ea_q    <= ea_d;
    end
  end

  assign acc = acc_q;
  assign ea  = ea_q;

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int IW       = 16,
  parameter int AW       = 16,
  parameter int DISP_W   = 8,
  parameter int MODE_POS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] b_in,
  input  logic [AW-1:0] x_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata
);

  ea_mode_t      mode;
  logic [AW-1:0] disp_ext;
  logic          ld_acc, ld_ea, post_idx;
  ea_src_e       ea_src;

  ea_field_decode #(
    .IW(IW), .AW(AW), .DISP_W(DISP_W), .MODE_POS(MODE_POS)
  ) u_decode (
    .instr    (instr),
    .mode     (mode),
    .disp_ext (disp_ext)
  );

  ea_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .mem_valid (mem_valid),
    .busy      (busy),
    .ld_acc    (ld_acc),
    .ld_ea     (ld_ea),
    .ea_src    (ea_src),
    .post_idx  (post_idx),
    .mem_req   (mem_req),
    .done      (done)
  );

  ea_datapath #(.AW(AW)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .disp_ext  (disp_ext),
    .pc_in     (pc_in),
    .b_in      (b_in),
    .x_in      (x_in),
    .ld_acc    (ld_acc),
    .ld_ea     (ld_ea),
    .ea_src    (ea_src),
    .post_idx  (post_idx),
    .mem_rdata (mem_rdata),
    .acc       (mem_addr),
    .ea        (ea)
  );

endmodule

// File: rtl/ea_unit_checker.sv
module ea_unit_checker #(
  parameter int IW       = 16,
  parameter int AW       = 16,
  parameter int MODE_POS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] instr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid
);

  logic m_b, m_i, m_x, accept;
  assign m_b    = instr[MODE_POS];
  assign m_i    = instr[MODE_POS+1];
  assign m_x    = instr[MODE_POS+2];
  assign accept = start && !busy;

  assert_single_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !m_i && !m_x |=> done && !busy);

  assert_x_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !m_i && m_x && !m_b |=> done);

  assert_bx_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !m_i && m_x && m_b |=> !done && busy);

  assert_bx_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !m_i && m_x && m_b |-> ##2 done);

  assert_fetch_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && m_i |=> mem_req && !done);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  assert_fetch_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> done && !mem_req);

  assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_ea_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

endmodule

bind ea_unit ea_unit_checker #(
  .IW(IW), .AW(AW), .MODE_POS(MODE_POS)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .instr     (instr),
  .busy      (busy),
  .done      (done),
  .ea        (ea),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid)
);

// File: tb/ea_unit_test.sv
module ea_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [15:0] ea;
    int          due;   // expected cycle stamp of done, -1 when latency depends on memory
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_in = '0, b_in = '0, x_in = '0;
  logic        busy, done, mem_req, mem_valid = 1'b0;
  logic [15:0] ea, mem_addr, mem_rdata = '0;

  int checks = 0, errors = 0, cyc = 0, mem_lat = 0;
  exp_t        exp_q[$];
  logic [15:0] ptr_q[$];

  ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .pc_in(pc_in), .b_in(b_in), .x_in(x_in),
    .busy(busy), .done(done), .ea(ea),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] sext(input logic [7:0] d);
    return {{8{d[7]}}, d};
  endfunction

  // Driver: issues one operation and pushes expectations into the scoreboard.
  task automatic issue(input logic [15:0] ins, input logic [15:0] p, input logic [15:0] b,
                       input logic [15:0] x, input int lat, input string req);
    exp_t        e;
    logic [15:0] ptr;
    bit          bb, ii, xx;
    bb = ins[8]; ii = ins[9]; xx = ins[10];
    @(negedge clk);
    while (busy) @(negedge clk);
    mem_lat = lat;
    e.req = req;
    if (ii) begin
      ptr   = (bb ? b : p) + sext(ins[7:0]);
      e.ea  = mem_fn(ptr) + (xx ? x : 16'h0000);
      e.due = -1;
      ptr_q.push_back(ptr);
    end else if (xx && bb) begin
      e.ea  = b + x + sext(ins[7:0]);
      e.due = cyc + 2;
    end else begin
      e.ea  = (bb ? b : (xx ? x : p)) + sext(ins[7:0]);
      e.due = cyc + 1;
    end
    exp_q.push_back(e);
    instr = ins; pc_in = p; b_in = b; x_in = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: register inputs are scrambled after the start edge; they must not matter.
    pc_in = ~p ^ 16'h1357; b_in = ~b ^ 16'h2468; x_in = ~x ^ 16'h0F0F;
    instr = ins ^ 16'h0700;
  endtask

  // Memory model: checks the pointer and answers after mem_lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && !mem_valid) begin
        logic [15:0] pexp;
        pexp = (ptr_q.size() > 0) ? ptr_q.pop_front() : 16'hxxxx;
        check(mem_addr === pexp, "R5/R6 pointer address", mem_addr, pexp);
        for (int i = 0; i < mem_lat; i++) begin
          @(negedge clk);
          check(mem_req === 1'b1 && mem_addr === pexp, "R5 request held", mem_addr, pexp);
        end
        mem_valid = 1'b1;
        mem_rdata = mem_fn(mem_addr);
        @(negedge clk);
        mem_valid = 1'b0;
        mem_rdata = 16'hDEAD;
        check(done === 1'b1 && mem_req === 1'b0, "R5 done after valid", {15'd0, done}, 16'h0001);
      end
    end
  end

  // Monitor: pops and compares on each done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8/R9 unexpected done", ea, 16'h0000);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(ea === e.ea, e.req, ea, e.ea);
          if (e.due >= 0)
            check(cyc == e.due, {e.req, " latency"}, cyc[15:0], e.due[15:0]);
          check(busy === 1'b0, "R9 done with busy low", {15'd0, busy}, 16'h0000);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog", 16'h0000, 16'h0001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R10 flags in reset",
          {13'd0, busy, done, mem_req}, 16'h0000);
    check(ea === 16'h0000, "R10 ea in reset", ea, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && ea === 16'h0000,
          "R10 idle after release", ea, 16'h0000);

    issue(16'h0005, 16'h1000, 16'h7777, 16'h6666, 0, "R2 P+d");
    issue(16'h0002, 16'hFFFF, 16'h0000, 16'h0000, 0, "R7 P+d wrap");
    issue(16'h01FC, 16'h1111, 16'h0000, 16'h2222, 0, "R2 B+d negative");
    issue(16'h0480, 16'h1111, 16'h3333, 16'h0200, 0, "R3 X+d minimum displacement");
    issue(16'h057F, 16'h0001, 16'h1000, 16'h0234, 0, "R4 B+X+d");
    issue(16'h05FF, 16'h0001, 16'h8000, 16'h8000, 0, "R7 B+X+d wrap");
    issue(16'hF805, 16'h1000, 16'h0000, 16'h0000, 0, "R1 opcode ignored");
    issue(16'h0210, 16'h2000, 16'h0000, 16'h0000, 0, "R5 P indirect zero latency");
    issue(16'h03F0, 16'h0000, 16'h3000, 16'h4444, 3, "R5 B indirect");
    issue(16'h0601, 16'h4000, 16'h0000, 16'h0100, 1, "R6 P indirect post-indexed");
    issue(16'h0700, 16'h0000, 16'h5000, 16'hFFFF, 5, "R6 B indirect post-indexed wrap");
    issue(16'h0404, 16'h0000, 16'h0000, 16'hFFFE, 0, "R3 X+d wrap");

    // R8: start pulsed during a long fetch must be ignored.
    issue(16'h0320, 16'h0000, 16'h0100, 16'h0000, 8, "R8 fetch before ignored start");
    check(busy === 1'b1, "R8 busy during fetch", {15'd0, busy}, 16'h0001);
    instr = 16'h0001; pc_in = 16'h0000; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;

    issue(16'h0081, 16'h0100, 16'h0000, 16'h0000, 0, "R2 after ignored start");
    issue(16'h077F, 16'h0000, 16'hFF90, 16'h0010, 2, "R6 B indirect post-indexed");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 one done per start", exp_q.size(), 16'h0000);
    check(ptr_q.size() == 0, "R5 all pointers fetched", ptr_q.size(), 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule